// File: doc/BRIEF.md
# Transmit Buffer Arbiter with Priority Drop

This block sits between a set of transmit buffers and a serial-bus protocol engine. It picks the highest-priority valid buffer, streams that frame word by word into the engine with the identifier word first, and only then asserts a start strobe. The engine reports the outcome: success, lost arbitration or a bus error. On success the block releases the buffer and pulses a done flag. On a loss or error it normally retries. An optional limit caps the number of retries, and a failure pulse follows when the cap is hit. An optional drop mode re-runs arbitration before each retry. If another pending buffer now outranks the current frame, the current frame is set aside and the better one is loaded instead.

Priority: a numerically lower identifier wins, and equal identifiers go to the lower buffer index. Software owns the valid flags. The block asks for a release through a one-hot clear pulse. A frame that is set aside keeps its valid flag and competes again later.

FSM states: `S_IDLE` (wait for any valid buffer), `S_LOAD` (stream the frame words), `S_START` (one-cycle start strobe), `S_WAIT` (await the engine outcome), `S_CHECK` (decide retry or drop). Transitions: IDLE→LOAD when a buffer is valid (winner latched, retry count cleared); LOAD→START after the last word; START→WAIT always; WAIT→IDLE on success or on a fault with the limit reached; WAIT→CHECK on a fault below the limit; CHECK→LOAD when drop mode finds a better buffer (retry count cleared); CHECK→START otherwise (retry count incremented).

Top module: `txarb_top`

## Requirements
- R1: When leaving idle, the selected buffer (`tx_buf`) is the valid buffer with the numerically lowest identifier; on equal identifiers the lowest index wins.
- R2: A load transfers words 0 to WORDS-1 of the selected buffer in ascending order, one per cycle with `ld_we` high; word 0 carries the identifier in its low 29 bits.
- R3: `eng_start` pulses for one cycle, in the cycle right after the last word of a load; a start after a fresh selection never comes before all WORDS words.
- R4: On `eng_ok` while waiting, `tx_done` is high in that cycle and `buf_clr` is one-hot with bit `tx_buf` set; otherwise `buf_clr` is zero except on a failure.
- R5: On `eng_arb_lost` or `eng_err` below the limit, without a drop, the same frame is restarted: `eng_start` pulses again with no `ld_we` cycle in between.
- R6: With `cfg_retry_en`=1 and limit L, the fault that arrives after L retries raises `tx_fail` for one cycle and a one-hot `buf_clr` for that buffer.
- R7: With `cfg_retry_en`=0, faults never raise `tx_fail` and retries continue without bound.
- R8: With `cfg_drop_en`=1, if a fault leaves a higher-priority valid buffer pending, the block loads that buffer (all WORDS words) instead of retrying; the dropped buffer is not cleared and is selected again later.
- R9: With `cfg_drop_en`=0, a better pending buffer does not interrupt retries of the current frame.
- R10: After a drop, the new frame's retry count starts from zero.
- R11: With no valid buffer, no load and no start occur; engine inputs are ignored outside the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_valid | input | NBUF | Per-buffer pending flag |
| buf_id | input | NBUF*IDW | Flattened identifiers, buffer i at bits [i*IDW +: IDW] |
| cfg_retry_en | input | 1 | Enable retry limit |
| cfg_retry_lim | input | RW | Maximum retries |
| cfg_drop_en | input | 1 | Enable drop in favour of higher priority |
| rd_sel | output | $clog2(NBUF) | Buffer read select |
| rd_word | output | $clog2(WORDS) | Buffer word read index |
| rd_data | input | DW | Buffer word read data |
| ld_we | output | 1 | Word strobe to engine |
| ld_word | output | $clog2(WORDS) | Word index to engine |
| ld_data | output | DW | Word data to engine |
| eng_start | output | 1 | Transmit start strobe |
| eng_ok | input | 1 | Engine reports success |
| eng_arb_lost | input | 1 | Engine reports arbitration loss |
| eng_err | input | 1 | Engine reports bus error |
| tx_buf | output | $clog2(NBUF) | Buffer currently in service |
| tx_done | output | 1 | Success pulse |
| tx_fail | output | 1 | Retry limit failure pulse |
| buf_clr | output | NBUF | One-hot release request |

## Verification
The bench covers identifier ties, both at index 0 and at non-zero indices. An arbiter with a reversed tie-break would serve the wrong buffer. It counts the words between a fresh selection and the start strobe: a loader that strobes early would put an unfinished identifier on the bus. A frame is dropped part way through its retries and then faulted again. A retry counter that is not cleared on the switch would fail that frame too soon. The bench also checks that the dropped buffer survives and is served afterwards. A design that released it would lose a pending frame.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_START,
        S_WAIT,
        S_CHECK
    } txarb_state_e;
endpackage

// File: rtl/txarb_pick.sv
// Priority selection: lowest identifier among valid buffers, ties to lower index.
module txarb_pick #(
    parameter int NBUF = 4,
    parameter int IDW  = 29,
    localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBUF-1:0]   valid,
    input  logic [NBUF*IDW-1:0] ids,
    output logic              any,
    output logic [BW-1:0]     win
);
    logic [IDW-1:0] best_id;

    always_comb begin
        any     = 1'b0;
        win     = '0;
        best_id = '1;
        for (int i = 0; i < NBUF; i++) begin
            if (valid[i] && (!any || ids[i*IDW +: IDW] < best_id)) begin
                any     = 1'b1;
                win     = BW'(i);
                best_id = ids[i*IDW +: IDW];
            end
        end
    end

    // R1: a reported winner is always a valid buffer
    a_r1_win_valid: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> valid[win]);
endmodule

// File: rtl/txarb_retry.sv
// Retry counter with optional limit.
module txarb_retry #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          en,
    input  logic [RW-1:0] lim,
    output logic          hit
);
    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (clr)          cnt <= '0;
        else if (inc && cnt != '1) cnt <= cnt + 1'b1;
    end

    assign hit = en && (cnt >= lim);

    // R10: a clear always restarts the count from zero
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/txarb_loader.sv
// Word sequencer for serial frame transfer, identifier word first.
module txarb_loader #(
    parameter int WORDS = 20,
    localparam int WW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic [WW-1:0] idx,
    output logic          last
);
    logic [WW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!go)   cnt <= '0;
        else if (!last) cnt <= cnt + 1'b1;
    end

    assign idx  = cnt;
    assign last = go && (cnt == WW'(WORDS - 1));

    // R2: consecutive load cycles step the word index by one
    a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $past(go) && !$past(last)) |-> idx == WW'($past(idx) + 1'b1));
    // R2: a load begins at the identifier word
    a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !$past(go)) |-> idx == '0);
endmodule

// File: rtl/txarb_top.sv
module txarb_top
    import txarb_pkg::*;
#(
    parameter int NBUF  = 4,
    parameter int IDW   = 29,
    parameter int WORDS = 20,
    parameter int DW    = 32,
    parameter int RW    = 4,
    localparam int BW   = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int WW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NBUF-1:0]     buf_valid,
    input  logic [NBUF*IDW-1:0] buf_id,
    input  logic                cfg_retry_en,
    input  logic [RW-1:0]       cfg_retry_lim,
    input  logic                cfg_drop_en,
    output logic [BW-1:0]       rd_sel,
    output logic [WW-1:0]       rd_word,
    input  logic [DW-1:0]       rd_data,
    output logic                ld_we,
    output logic [WW-1:0]       ld_word,
    output logic [DW-1:0]       ld_data,
    output logic                eng_start,
    input  logic                eng_ok,
    input  logic                eng_arb_lost,
    input  logic                eng_err,
    output logic [BW-1:0]       tx_buf,
    output logic                tx_done,
    output logic                tx_fail,
    output logic [NBUF-1:0]     buf_clr
);
    txarb_state_e st, nx;
    logic [BW-1:0] cur;
    logic          p_any;
    logic [BW-1:0] p_win;
    logic          r_clr, r_inc, r_hit;
    logic [WW-1:0] l_idx;
    logic          l_last;
    logic          fault, drop;

    txarb_pick #(.NBUF(NBUF), .IDW(IDW)) u_pick (
        .clk(clk), .rst_n(rst_n), .valid(buf_valid), .ids(buf_id),
        .any(p_any), .win(p_win)
    );

    txarb_retry #(.RW(RW)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(r_clr), .inc(r_inc),
        .en(cfg_retry_en), .lim(cfg_retry_lim), .hit(r_hit)
    );

    txarb_loader #(.WORDS(WORDS)) u_load (
        .clk(clk), .rst_n(rst_n), .go(st == S_LOAD), .idx(l_idx), .last(l_last)
    );

    assign fault = eng_arb_lost || eng_err;
    assign drop  = cfg_drop_en && p_any && (p_win != cur);

    // next-state logic
    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:  if (p_any) nx = S_LOAD;
            S_LOAD:  if (l_last) nx = S_START;
            S_START: nx = S_WAIT;
            S_WAIT: begin
                if (eng_ok)      nx = S_IDLE;
                else if (fault)  nx = r_hit ? S_IDLE : S_CHECK;
            end
            S_CHECK: nx = drop ? S_LOAD : S_START;
            default: nx = S_IDLE;
        endcase
    end

    // state register and served buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cur <= '0;
        end else begin
            st <= nx;
            if ((st == S_IDLE && p_any) || (st == S_CHECK && drop))
                cur <= p_win;
        end
    end

    // outputs
    always_comb begin
        rd_sel    = cur;
        rd_word   = l_idx;
        ld_we     = (st == S_LOAD);
        ld_word   = l_idx;
        ld_data   = rd_data;
        eng_start = (st == S_START);
        tx_buf    = cur;
        tx_done   = (st == S_WAIT) && eng_ok;
        tx_fail   = (st == S_WAIT) && !eng_ok && fault && r_hit;
        buf_clr   = (tx_done || tx_fail) ? (NBUF'(1) << cur) : '0;
        r_clr     = (st == S_IDLE && p_any) || (st == S_CHECK && drop);
        r_inc     = (st == S_CHECK) && !drop;
    end

    // R3: a start that follows a load follows its final word
    a_r3_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && $past(ld_we)) |-> $past(ld_word) == WW'(WORDS - 1));
    // R5: start and load never overlap
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !ld_we);
    // R4: release requests are one-hot and only with an outcome
    a_r4_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_clr) && (buf_clr != '0 || !(tx_done || tx_fail)));
    // R4: success and failure exclusive
    a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_fail));
    // R7: failure only when a limit is active
    a_r7_fail_needs_limit: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fail |-> cfg_retry_en);
    // R3: start strobe lasts one cycle
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
endmodule

// File: tb/tb_txarb_top.sv
module tb_txarb_top;
    localparam int NBUF = 4, IDW = 29, WORDS = 20, DW = 32, RW = 4;
    localparam int NV = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NBUF-1:0]     bv;
    logic [IDW-1:0]      bid [NBUF];
    logic [NBUF*IDW-1:0] buf_id;
    logic                retry_en, drop_en;
    logic [RW-1:0]       retry_lim;
    logic [1:0]          rd_sel;
    logic [4:0]          rd_word;
    logic [DW-1:0]       rd_data;
    logic                ld_we, eng_start, eng_ok, eng_lost, eng_err;
    logic [4:0]          ld_word;
    logic [DW-1:0]       ld_data;
    logic [1:0]          tx_buf;
    logic                tx_done, tx_fail;
    logic [NBUF-1:0]     buf_clr;

    always_comb for (int i = 0; i < NBUF; i++) buf_id[i*IDW +: IDW] = bid[i];
    assign rd_data = (rd_word == 0) ? {3'b0, bid[rd_sel]}
                                    : {8'(rd_sel), 8'(rd_word), 16'hA5A5};

    txarb_top #(.NBUF(NBUF), .IDW(IDW), .WORDS(WORDS), .DW(DW), .RW(RW)) dut (
        .clk(clk), .rst_n(rst_n), .buf_valid(bv), .buf_id(buf_id),
        .cfg_retry_en(retry_en), .cfg_retry_lim(retry_lim), .cfg_drop_en(drop_en),
        .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data),
        .ld_we(ld_we), .ld_word(ld_word), .ld_data(ld_data), .eng_start(eng_start),
        .eng_ok(eng_ok), .eng_arb_lost(eng_lost), .eng_err(eng_err),
        .tx_buf(tx_buf), .tx_done(tx_done), .tx_fail(tx_fail), .buf_clr(buf_clr)
    );

    int checks = 0, failures = 0;

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // waits for eng_start; counts load words and checks their order and content
    task automatic wait_start(output int nw, output logic [31:0] first);
        logic seen = 1'b0;
        nw = 0; first = '0;
        for (int c = 0; c < 200 && !seen; c++) begin
            @(negedge clk);
            if (ld_we) begin
                if (nw == 0) first = ld_data;
                if (ld_word != 5'(nw)) chk(1'b0, "R2 word order", ld_word, nw);
                nw++;
            end
            if (eng_start) seen = 1'b1;
        end
        chk(seen, "R3 start seen", seen, 1);
    endtask

    // drives one engine outcome for a cycle and samples the block's response
    task automatic outcome(input int kind, output logic done, output logic fail,
                           output logic [NBUF-1:0] clr);
        @(negedge clk);
        eng_ok = (kind == 0); eng_lost = (kind == 1); eng_err = (kind == 2);
        #1;
        done = tx_done; fail = tx_fail; clr = buf_clr;
        bv = bv & ~buf_clr;
        @(negedge clk);
        eng_ok = 0; eng_lost = 0; eng_err = 0;
    endtask

    localparam logic [3:0]     T_V   [NV] = '{4'b0001, 4'b1111, 4'b1110, 4'b1111, 4'b1010, 4'b0100};
    localparam logic [28:0]    T_ID  [NV][4] = '{
        '{29'd100, 29'd0, 29'd0, 29'd0},
        '{29'd40, 29'd30, 29'd20, 29'd10},
        '{29'd5, 29'd30, 29'd20, 29'd25},
        '{29'd7, 29'd7, 29'd9, 29'd7},
        '{29'd1, 29'd50, 29'd1, 29'd50},
        '{29'd0, 29'd0, 29'h1FFFFFFF, 29'd0}};
    localparam int             T_EXP [NV] = '{0, 3, 2, 0, 1, 2};

    initial begin
        #2_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nw;
        logic [31:0] first;
        logic d, f;
        logic [NBUF-1:0] c;
        bv = '0; for (int i = 0; i < NBUF; i++) bid[i] = '0;
        retry_en = 0; retry_lim = '0; drop_en = 0;
        eng_ok = 0; eng_lost = 0; eng_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!ld_we && !eng_start && !tx_done && !tx_fail && buf_clr == 0,
            "R11 reset outputs idle", {ld_we, eng_start, tx_done, tx_fail}, 0);

        // R11: nothing valid, engine inputs pulsed while idle
        eng_ok = 1; eng_err = 1;
        begin
            logic act = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (ld_we || eng_start || tx_done || tx_fail || buf_clr != 0) act = 1'b1;
            end
            chk(!act, "R11 no activity without valid buffer", act, 0);
        end
        eng_ok = 0; eng_err = 0;

        // table: selection, full load, success (R1 R2 R3 R4)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            for (int i = 0; i < NBUF; i++) bid[i] = T_ID[v][i];
            bv = T_V[v];
            wait_start(nw, first);
            chk(tx_buf == 2'(T_EXP[v]), "R1 selected buffer", tx_buf, T_EXP[v]);
            chk(nw == WORDS, "R3 words before start", nw, WORDS);
            chk(first == {3'b0, T_ID[v][T_EXP[v]]}, "R2 identifier first", first, T_ID[v][T_EXP[v]]);
            outcome(0, d, f, c);
            chk(d && !f, "R4 done pulse", {d, f}, 2'b10);
            chk(c == 4'(1 << T_EXP[v]), "R4 one-hot release", c, 1 << T_EXP[v]);
            bv = '0;
        end

        // R6: limit 2 -> two retries, third fault fails
        @(negedge clk);
        retry_en = 1; retry_lim = 4'd2; drop_en = 0;
        bid[1] = 29'd33; bv = 4'b0010;
        wait_start(nw, first);
        for (int k = 0; k < 2; k++) begin
            outcome(1 + (k % 2), d, f, c);
            chk(!f && c == 0, "R6 no fail below limit", f, 0);
            wait_start(nw, first);
            chk(nw == 0, "R5 retry without reload", nw, 0);
        end
        outcome(2, d, f, c);
        chk(f && !d, "R6 fail at limit", f, 1);
        chk(c == 4'b0010, "R6 release on fail", c, 4'b0010);
        repeat (3) @(negedge clk);
        chk(!ld_we && !eng_start, "R6 idle after fail", eng_start, 0);

        // R7: unlimited retries
        retry_en = 0; retry_lim = 4'd0;
        bid[0] = 29'd9; bv = 4'b0001;
        wait_start(nw, first);
        begin
            logic anyf = 1'b0;
            for (int k = 0; k < 6; k++) begin
                outcome(1, d, f, c);
                if (f || c != 0) anyf = 1'b1;
                wait_start(nw, first);
            end
            chk(!anyf, "R7 no fail with limit off", anyf, 0);
        end
        outcome(0, d, f, c);
        chk(d && c == 4'b0001, "R7 success after many retries", c, 1);

        // R9: drop disabled, better frame appears
        @(negedge clk);
        bid[2] = 29'd60; bid[3] = 29'd2; bv = 4'b0100;
        wait_start(nw, first);
        bv = 4'b1100;
        outcome(1, d, f, c);
        wait_start(nw, first);
        chk(nw == 0 && tx_buf == 2'd2, "R9 keeps current frame", tx_buf, 2);
        outcome(0, d, f, c);
        chk(c == 4'b0100, "R9 current frame completes", c, 4'b0100);
        wait_start(nw, first);
        chk(tx_buf == 2'd3, "R1 remaining buffer served", tx_buf, 3);
        outcome(0, d, f, c);
        bv = '0;

        // R8 R10: drop with limit 2
        @(negedge clk);
        retry_en = 1; retry_lim = 4'd2; drop_en = 1;
        bid[0] = 29'd50; bid[1] = 29'd10; bv = 4'b0001;
        wait_start(nw, first);
        outcome(1, d, f, c);              // A: count 0 -> retry
        wait_start(nw, first);
        chk(nw == 0, "R5 retry of A", nw, 0);
        bv = 4'b0011;
        outcome(2, d, f, c);              // A: count 1 -> drop
        chk(!f && c == 0, "R8 dropped frame not released", c, 0);
        wait_start(nw, first);
        chk(tx_buf == 2'd1 && nw == WORDS, "R8 better frame loaded", {tx_buf, 5'(nw)}, {2'd1, 5'(WORDS)});
        chk(first == 32'd10, "R8 new identifier first", first, 10);
        outcome(1, d, f, c);
        wait_start(nw, first);
        outcome(1, d, f, c);
        chk(!f, "R10 count restarted after drop", f, 0);
        wait_start(nw, first);
        outcome(1, d, f, c);
        chk(f && c == 4'b0010, "R10 fail after full retries", c, 4'b0010);
        wait_start(nw, first);
        chk(tx_buf == 2'd0 && nw == WORDS, "R8 dropped frame served again", tx_buf, 0);
        outcome(0, d, f, c);
        chk(d && c == 4'b0001, "R8 dropped frame completes", c, 1);
        bv = '0;

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule